// File: doc/BRIEF.md
# Memory Controller Local Request Front-End

This block is the user-side request port of a double-data-rate memory controller. A user issues a read or a write with an address and a burst size. The port applies ready/accept backpressure. It holds at most one request and passes it to a back-end command port once memory initialization is reported complete. Until then, requests are still taken and parked.

For a write, the port asks the user for each data word one cycle ahead and forwards the words to the back-end. For a read, the back-end returns words through the port. The user sees an early-valid strobe a fixed number of cycles ahead of the data-valid strobe. A refresh issued by the back-end is echoed to the user as a single-cycle acknowledge.

The allowed burst size is half the memory burst length. Sizes outside the legal range are clamped and flagged.

Top module: `mem_req_frontend`

## Requirements
- R1: The user write and read data buses are each twice the width of the memory data bus (parameter `MEM_DW`).
- R2: A request is accepted in a cycle where `usr_ready` is high and `usr_rd_req` or `usr_wr_req` is high; read wins if both are high. From the next cycle, `usr_ready` stays low until the command has been taken by the back-end and, for a write, every data word has been pulled.
- R3: `usr_init_done` follows `be_init_done` one cycle late. `be_cmd_vld` is never high while `usr_init_done` is low, so requests taken earlier wait.
- R4: The largest local burst size is `MEM_BL/2`. A requested size from 1 to that maximum reaches `be_cmd_size` unchanged, with the address and direction (`be_cmd_rd` = 1 for read) of the accepted request.
- R5: A requested size of 0 or above the maximum is sent as the maximum, and `usr_size_err` is high for the one cycle after that acceptance.
- R6: With `MEM_BL` = 2, the size input is ignored: `be_cmd_size` is always 1 and `usr_size_err` never rises.
- R7: After a write command is taken (`be_cmd_vld` and `be_cmd_rdy` high together), `usr_wdata_pull` is high for exactly the burst size in consecutive cycles, starting the next cycle. It is never high otherwise.
- R8: `be_wdata_vld` is high in the cycle after each `usr_wdata_pull` cycle, and `be_wdata` then carries `usr_wdata` of that cycle.
- R9: `usr_rdata_early` is `be_rd_vld` delayed one cycle. `usr_rdata_vld` follows `usr_rdata_early` three cycles later, with `usr_rdata` equal to the `be_rdata` sampled alongside the matching `be_rd_vld`. Words keep their order.
- R10: `usr_refresh_ack` is high for exactly one cycle, in the cycle after each rising edge of `be_refresh`, however long `be_refresh` stays high.
- R11: In reset and on the first cycle after it, `usr_ready` is 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_rd_req | input | 1 | Read request |
| usr_wr_req | input | 1 | Write request |
| usr_addr | input | ADDR_W | Request address |
| usr_size | input | SIZE_W | Requested burst size in words |
| usr_wdata | input | 2*MEM_DW | Write data word |
| usr_ready | output | 1 | Request can be accepted this cycle |
| usr_init_done | output | 1 | Memory initialization complete |
| usr_wdata_pull | output | 1 | Present the next write word in the following cycle |
| usr_rdata | output | 2*MEM_DW | Read data word |
| usr_rdata_vld | output | 1 | Read data word valid |
| usr_rdata_early | output | 1 | Read valid, three cycles ahead |
| usr_size_err | output | 1 | Illegal size was clamped |
| usr_refresh_ack | output | 1 | A refresh was issued |
| be_init_done | input | 1 | Back-end initialization complete |
| be_cmd_vld | output | 1 | Command offered to back-end |
| be_cmd_rd | output | 1 | Command is a read |
| be_cmd_addr | output | ADDR_W | Command address |
| be_cmd_size | output | SIZE_W | Command burst size |
| be_cmd_rdy | input | 1 | Back-end takes the command |
| be_wdata | output | 2*MEM_DW | Write word to back-end |
| be_wdata_vld | output | 1 | Write word valid |
| be_rd_vld | input | 1 | Back-end returns a read word |
| be_rdata | input | 2*MEM_DW | Returned read word |
| be_refresh | input | 1 | Refresh issued (level) |

## Verification
The first 40 cycles keep initialization low while requests arrive. This separates parking a request from forwarding it. Request direction, size (0 to 7), back-end readiness, read returns and refresh levels are then varied freely. Collisions of read and write requests, and back-end stalls during a held request, all occur and are compared against a behavioural model every cycle. Sizes 0, 5, 6 and 7 exercise clamping against legal sizes passed unchanged. Multi-cycle refresh levels show an acknowledge per edge rather than per cycle. A second instance with memory burst length 2 runs on the same stimulus to show the size input has no effect there.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_WDAT} req_st_e;

  function automatic logic size_bad(input int unsigned req, input int unsigned max_sz);
    return (max_sz > 1) && ((req == 0) || (req > max_sz));
  endfunction

  function automatic int unsigned clamp_size(input int unsigned req, input int unsigned max_sz);
    if (max_sz <= 1) return 1;
    if (size_bad(req, max_sz)) return max_sz;
    return req;
  endfunction
endpackage

// File: rtl/mrf_req_hold.sv
module mrf_req_hold
  import mrf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 3,
  parameter int MAX_LOCAL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              init_in,
  input  logic              cmd_rdy,
  output logic              ready,
  output logic              init_done,
  output logic              cmd_vld,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [SIZE_W-1:0] cmd_size,
  output logic              pull,
  output logic              size_err
);
  req_st_e           st;
  logic              init_q;
  logic              p_rd;
  logic [ADDR_W-1:0] p_addr;
  logic [SIZE_W-1:0] p_size;
  logic [SIZE_W-1:0] left;
  logic              err_q;

  // named internal events
  logic              accept;
  logic              cmd_fire;
  logic              req_bad;
  logic [SIZE_W-1:0] eff_size;

  assign ready    = (st == ST_IDLE);
  assign accept   = ready && (rd_req || wr_req);
  assign req_bad  = size_bad(32'(size), MAX_LOCAL);
  assign eff_size = SIZE_W'(clamp_size(32'(size), MAX_LOCAL));
  assign cmd_vld  = (st == ST_HOLD) && init_q;
  assign cmd_fire = cmd_vld && cmd_rdy;
  assign pull     = (st == ST_WDAT);
  assign cmd_rd   = p_rd;
  assign cmd_addr = p_addr;
  assign cmd_size = p_size;
  assign init_done = init_q;
  assign size_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      init_q <= 1'b0;
      p_rd   <= 1'b0;
      p_addr <= '0;
      p_size <= '0;
      left   <= '0;
      err_q  <= 1'b0;
    end else begin
      init_q <= init_in;
      err_q  <= accept && req_bad;
      unique case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_HOLD;
          p_rd   <= rd_req;
          p_addr <= addr;
          p_size <= eff_size;
        end
        ST_HOLD: if (cmd_fire) begin
          if (p_rd) st <= ST_IDLE;
          else begin
            st   <= ST_WDAT;
            left <= p_size;
          end
        end
        ST_WDAT: begin
          left <= left - 1'b1;
          if (left == SIZE_W'(1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  cmd_wait_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> init_done);
  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  // R7
  pull_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !cmd_rd) |=> pull);
  // R4
  cmd_size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (cmd_size >= SIZE_W'(1) && 32'(cmd_size) <= MAX_LOCAL));
  // R5
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> !size_err);
endmodule

// File: rtl/mrf_rd_return.sv
module mrf_rd_return #(
  parameter int DW         = 16,
  parameter int EARLY_LEAD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic          early,
  output logic          out_vld,
  output logic [DW-1:0] out_data
);
  localparam int DEPTH = EARLY_LEAD + 1;

  logic          v_q [DEPTH];
  logic [DW-1:0] d_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      d_q[0] <= '0;
    end else begin
      v_q[0] <= in_vld;
      d_q[0] <= in_data;
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[i] <= 1'b0;
        d_q[i] <= '0;
      end else begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign early    = v_q[0];
  assign out_vld  = v_q[DEPTH-1];
  assign out_data = d_q[DEPTH-1];

  if (EARLY_LEAD == 3) begin : g_lead_chk
    // R9
    early_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      early |-> ##3 out_vld);
  end
endmodule

// File: rtl/mrf_refresh_ack.sv
module mrf_refresh_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_lvl,
  output logic ack
);
  logic lvl_q;
  logic rise;

  assign rise = refresh_lvl && !lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      ack   <= 1'b0;
    end else begin
      lvl_q <= refresh_lvl;
      ack   <= rise;
    end
  end

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

// File: rtl/mem_req_frontend.sv
module mem_req_frontend #(
  parameter int MEM_DW     = 8,
  parameter int ADDR_W     = 16,
  parameter int MEM_BL     = 8,
  parameter int SIZE_W     = 3,
  parameter int EARLY_LEAD = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                usr_rd_req,
  input  logic                usr_wr_req,
  input  logic [ADDR_W-1:0]   usr_addr,
  input  logic [SIZE_W-1:0]   usr_size,
  input  logic [2*MEM_DW-1:0] usr_wdata,
  output logic                usr_ready,
  output logic                usr_init_done,
  output logic                usr_wdata_pull,
  output logic [2*MEM_DW-1:0] usr_rdata,
  output logic                usr_rdata_vld,
  output logic                usr_rdata_early,
  output logic                usr_size_err,
  output logic                usr_refresh_ack,
  input  logic                be_init_done,
  output logic                be_cmd_vld,
  output logic                be_cmd_rd,
  output logic [ADDR_W-1:0]   be_cmd_addr,
  output logic [SIZE_W-1:0]   be_cmd_size,
  input  logic                be_cmd_rdy,
  output logic [2*MEM_DW-1:0] be_wdata,
  output logic                be_wdata_vld,
  input  logic                be_rd_vld,
  input  logic [2*MEM_DW-1:0] be_rdata,
  input  logic                be_refresh
);
  localparam int LOC_DW    = 2 * MEM_DW;
  localparam int MAX_LOCAL = (MEM_BL / 2 < 1) ? 1 : MEM_BL / 2;

  logic wvld_q;

  mrf_req_hold #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_LOCAL(MAX_LOCAL)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .rd_req(usr_rd_req), .wr_req(usr_wr_req), .addr(usr_addr), .size(usr_size),
    .init_in(be_init_done), .cmd_rdy(be_cmd_rdy),
    .ready(usr_ready), .init_done(usr_init_done),
    .cmd_vld(be_cmd_vld), .cmd_rd(be_cmd_rd), .cmd_addr(be_cmd_addr), .cmd_size(be_cmd_size),
    .pull(usr_wdata_pull), .size_err(usr_size_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wvld_q <= 1'b0;
    else        wvld_q <= usr_wdata_pull;
  end

  assign be_wdata_vld = wvld_q;
  assign be_wdata     = usr_wdata;

  mrf_rd_return #(.DW(LOC_DW), .EARLY_LEAD(EARLY_LEAD)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .in_vld(be_rd_vld), .in_data(be_rdata),
    .early(usr_rdata_early), .out_vld(usr_rdata_vld), .out_data(usr_rdata)
  );

  mrf_refresh_ack u_ref (
    .clk(clk), .rst_n(rst_n), .refresh_lvl(be_refresh), .ack(usr_refresh_ack)
  );

  // R8
  wdata_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wdata_pull |=> be_wdata_vld);
endmodule

// File: tb/sim_mem_req_frontend.sv
module sim_mem_req_frontend;
  localparam int MEM_DW = 8;
  localparam int DW     = 2 * MEM_DW;
  localparam int AW     = 16;
  localparam int SW     = 3;
  localparam int MAXSZ  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 1'b0, wr_req = 1'b0, init_in = 1'b0, cmd_rdy = 1'b0;
  logic          rdv_in = 1'b0, refr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [SW-1:0] size = '0;
  logic [DW-1:0] wdata = '0, rdata_in = '0;

  logic          ready, initd, pull, rvld, early, serr, ack, cvld, crd, wvld;
  logic [DW-1:0] rdata, bwdata;
  logic [AW-1:0] caddr;
  logic [SW-1:0] csize;

  logic          r1_ready, r1_initd, r1_pull, r1_rvld, r1_early, r1_serr, r1_ack, r1_cvld, r1_crd, r1_wvld;
  logic [DW-1:0] r1_rdata, r1_bwdata;
  logic [AW-1:0] r1_caddr;
  logic [SW-1:0] r1_csize;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mem_req_frontend #(.MEM_DW(MEM_DW), .ADDR_W(AW), .MEM_BL(8), .SIZE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .usr_rd_req(rd_req), .usr_wr_req(wr_req), .usr_addr(addr),
    .usr_size(size), .usr_wdata(wdata), .usr_ready(ready), .usr_init_done(initd),
    .usr_wdata_pull(pull), .usr_rdata(rdata), .usr_rdata_vld(rvld), .usr_rdata_early(early),
    .usr_size_err(serr), .usr_refresh_ack(ack), .be_init_done(init_in), .be_cmd_vld(cvld),
    .be_cmd_rd(crd), .be_cmd_addr(caddr), .be_cmd_size(csize), .be_cmd_rdy(cmd_rdy),
    .be_wdata(bwdata), .be_wdata_vld(wvld), .be_rd_vld(rdv_in), .be_rdata(rdata_in),
    .be_refresh(refr));

  mem_req_frontend #(.MEM_DW(MEM_DW), .ADDR_W(AW), .MEM_BL(2), .SIZE_W(SW)) u1 (
    .clk(clk), .rst_n(rst_n), .usr_rd_req(rd_req), .usr_wr_req(wr_req), .usr_addr(addr),
    .usr_size(size), .usr_wdata(wdata), .usr_ready(r1_ready), .usr_init_done(r1_initd),
    .usr_wdata_pull(r1_pull), .usr_rdata(r1_rdata), .usr_rdata_vld(r1_rvld), .usr_rdata_early(r1_early),
    .usr_size_err(r1_serr), .usr_refresh_ack(r1_ack), .be_init_done(init_in), .be_cmd_vld(r1_cvld),
    .be_cmd_rd(r1_crd), .be_cmd_addr(r1_caddr), .be_cmd_size(r1_csize), .be_cmd_rdy(cmd_rdy),
    .be_wdata(r1_bwdata), .be_wdata_vld(r1_wvld), .be_rd_vld(rdv_in), .be_rdata(rdata_in),
    .be_refresh(refr));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 holding, 2 pulling write words
  int          m_phase = 0;
  int          m_left  = 0;
  bit          m_rd = 0, m_init = 0, m_err = 0, m_pull_prev = 0, m_ack = 0, m_refp = 0;
  int          m_addr = 0, m_size = 0;
  bit          rdv_hist [$];
  logic [DW-1:0] rdd_hist [$];

  initial begin
    for (int i = 0; i < 4; i++) begin rdv_hist.push_back(1'b0); rdd_hist.push_back('0); end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int req_sz, exp_sz;
    bit fire;
    repeat (3) @(negedge clk);
    // R11 reset values
    chk("R11", "ready", ready, 1);
    chk("R11", "pull", pull, 0);
    chk("R11", "cmd_vld", cvld, 0);
    chk("R11", "rdata_vld", rvld, 0);
    chk("R11", "ack", ack, 0);
    chk("R11", "init_done", initd, 0);
    chk("R1", "rdata width", $bits(rdata), 2 * MEM_DW);
    chk("R1", "wdata width", $bits(wdata), 2 * MEM_DW);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc == 0) chk("R11", "ready after reset", ready, 1);
      // compare outputs of this cycle with the model
      chk("R2", "ready", ready, m_phase == 0);
      chk("R3", "init_done", initd, m_init);
      chk("R3", "cmd_vld", cvld, (m_phase == 1) && m_init);
      if (cvld) begin
        chk("R4", "cmd_rd", crd, m_rd);
        chk("R4", "cmd_addr", caddr, m_addr);
        chk("R4", "cmd_size", csize, m_size);
      end
      chk("R7", "pull", pull, m_phase == 2);
      chk("R5", "size_err", serr, m_err);
      chk("R8", "wdata_vld", wvld, m_pull_prev);
      chk("R9", "early", early, rdv_hist[3]);
      chk("R9", "rdata_vld", rvld, rdv_hist[0]);
      if (rvld) chk("R9", "rdata", rdata, rdd_hist[0]);
      chk("R10", "refresh_ack", ack, m_ack);
      chk("R6", "bl2 size_err", r1_serr, 0);
      if (r1_cvld) chk("R6", "bl2 cmd_size", r1_csize, 1);

      // drive this cycle's inputs
      init_in  = (cyc >= 40);
      rd_req   = ($urandom % 3) == 0;
      wr_req   = ($urandom % 3) == 0;
      addr     = AW'($urandom);
      size     = SW'($urandom % 8);
      wdata    = DW'($urandom);
      cmd_rdy  = ($urandom % 3) != 0;
      rdv_in   = ($urandom % 3) == 0;
      rdata_in = DW'($urandom);
      if (($urandom % 5) == 0) refr = ~refr;
      #1;
      if (wvld) chk("R8", "be_wdata", bwdata, wdata);

      // advance the model to the next cycle
      req_sz = int'(size);
      exp_sz = (req_sz == 0 || req_sz > MAXSZ) ? MAXSZ : req_sz;
      fire = (m_phase == 1) && m_init && cmd_rdy;
      m_pull_prev = (m_phase == 2);
      m_err = (m_phase == 0) && (rd_req || wr_req) && (req_sz == 0 || req_sz > MAXSZ);
      if (m_phase == 0) begin
        if (rd_req || wr_req) begin
          m_phase = 1; m_rd = rd_req; m_addr = int'(addr); m_size = exp_sz;
        end
      end else if (m_phase == 1) begin
        if (fire) begin
          if (m_rd) m_phase = 0;
          else begin m_phase = 2; m_left = m_size; end
        end
      end else begin
        m_left--;
        if (m_left == 0) m_phase = 0;
      end
      m_init = init_in;
      rdv_hist.push_back(rdv_in);   void'(rdv_hist.pop_front());
      rdd_hist.push_back(rdata_in); void'(rdd_hist.pop_front());
      m_ack  = refr && !m_refp;
      m_refp = refr;
      @(negedge clk);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule